// File: doc/BRIEF.md
# Dual-Output Multi-Mode PWM Generator

This block produces one pulse-width-modulated channel on two pins, a high-side output and a low-side output. A free-running counter divides time into periods of a programmed number of clock cycles. A duty count sets how many cycles at the start of each period carry the active level. A one-hot mode field chooses the waveform:

- single-output drive on the high side only;
- a complementary pair, where the low side mirrors the high side inverted;
- alternating push-pull drive, where successive periods hand the pulse from one side to the other.

A polarity bit flips the active sense in every mode.

The configuration inputs may change at any time. The channel samples them only where a new period begins. A waveform in flight is therefore never cut short or stretched by a reprogramming. When enable is low, the counter stays at zero and both pins rest at the idle level that the polarity selects. The first period begins on the clock edge after enable is seen high.

Top module: `pwm2_gen`

## Requirements
- R1: The mode field `mode_i` is one-hot. Bit 0 selects single-output mode, bit 1 selects complementary mode, and bit 2 selects push-pull mode.
- R2: When several mode bits are set, the lowest set bit decides the mode. A mode field of 3'b000 behaves as single-output mode.
- R3: A running period lasts `period_i` clock cycles, with a value of 0 treated as 1. The active level is present for the first `duty_i` cycles of the period. A duty of 0 yields no active cycle. A duty at or above the period keeps the output active for the whole period.
- R4: In single-output mode the pulse train appears on `out_hi`, and `out_lo` stays at its idle level.
- R5: In complementary mode, while running, `out_lo` is always the inverse of `out_hi`.
- R6: In push-pull mode the pulse goes to `out_hi` in one period and to `out_lo` in the next, and the non-pulsing side stays idle. The first push-pull period after enable, or after a change into push-pull from another mode, pulses `out_hi`.
- R7: With `inv_i` = 1, both outputs are the bitwise inverse of their waveform with `inv_i` = 0, in every mode. In push-pull this means both pins idle high and carry low-going alternating pulses.
- R8: Changes to the period, duty, mode and polarity inputs take effect only from the start of the next period.
- R9: While enable is low, the counter is held at zero and both outputs equal the polarity bit sampled on the previous edge. During reset both outputs are 0. After enable is sampled high, the first output cycle is cycle 0 of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable |
| period_i | input | CW | Period length in clock cycles |
| duty_i | input | CW | Active cycles per period |
| mode_i | input | 3 | One-hot waveform mode request |
| inv_i | input | 1 | Polarity: 1 inverts both outputs |
| out_hi | output | 1 | High-side output |
| out_lo | output | 1 | Low-side output |

## Verification
The bench probes mode fields with several bits set, and the all-zero field. A resolver that let a higher bit win, or that treated zero as off, would put a pulse on the wrong pin or drop it entirely.

Duty values of zero, equal to the period and above the period check that the comparison neither leaks one active cycle nor loses the last one.

A mid-period reprogramming checks that a design which applied new settings at once would lengthen the pulse in the current period.

A push-pull run that leaves the mode and comes back checks that the alternation restarts on the high side. A design that kept toggling its phase through the other mode would pulse the low side first.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;

  // Resolved waveform mode, kept in the period shadow register.
  typedef enum logic [1:0] {
    MD_SINGLE = 2'd0,
    MD_COMPL  = 2'd1,
    MD_ALT    = 2'd2
  } drive_mode_e;

  localparam int unsigned MODE_W = 3;

endpackage

// File: rtl/pwm2_mode_sel.sv
module pwm2_mode_sel
  import pwm2_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output drive_mode_e       mode_o
);

  // Lowest set bit wins; an empty field falls back to single-output drive.
  always_comb begin
    if (mode_i[0])      mode_o = MD_SINGLE;
    else if (mode_i[1]) mode_o = MD_COMPL;
    else if (mode_i[2]) mode_o = MD_ALT;
    else                mode_o = MD_SINGLE;
  end

  always_comb begin
    if (mode_i[1] && mode_i[2]) begin
      a_r2_low_bit_wins : assert (mode_o != MD_ALT);
    end
  end

endmodule

// File: rtl/pwm2_timebase.sv
module pwm2_timebase
  import pwm2_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] duty_i,
  input  drive_mode_e   mode_i,
  input  logic          inv_i,
  output logic          run_o,
  output logic          act_o,
  output logic          phase_o,
  output drive_mode_e   mode_o,
  output logic          inv_o
);

  localparam int unsigned XW = CW + 1;

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] per_q, duty_q;
  drive_mode_e   mode_q;
  logic          inv_q;
  logic          phase_q, phase_d;
  logic [XW-1:0] cnt_inc;
  logic          last, load;

  // Next-state logic
  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
    last    = (cnt_inc >= {1'b0, per_q});
    load    = !en_i || !run_q || last;
    run_d   = en_i;

    if (load) cnt_d = '0;
    else      cnt_d = cnt_inc[CW-1:0];

    if (!en_i || !run_q)
      phase_d = 1'b0;
    else if (last)
      phase_d = (mode_q == MD_ALT && mode_i == MD_ALT) ? !phase_q : 1'b0;
    else
      phase_d = phase_q;
  end

  // Counter and run state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  // Shadow settings, loaded only at a period boundary or while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      duty_q <= '0;
      mode_q <= MD_SINGLE;
      inv_q  <= 1'b0;
    end else if (load) begin
      per_q  <= per_i;
      duty_q <= duty_i;
      mode_q <= mode_i;
      inv_q  <= inv_i;
    end
  end

  assign run_o   = run_q;
  assign act_o   = run_q && (cnt_q < duty_q);
  assign phase_o = phase_q;
  assign mode_o  = mode_q;
  assign inv_o   = inv_q;

  a_r3_cnt_in_period : assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q == '0 || cnt_q < per_q));

  a_r9_idle_cnt_zero : assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0 && !run_q));

  a_r8_hold_mid_period : assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && run_q && !last) |=> ($stable(per_q) && $stable(duty_q) &&
                                  $stable(mode_q) && $stable(inv_q)));

  a_r6_alt_toggles : assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && run_q && last && mode_q == MD_ALT && mode_i == MD_ALT)
      |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/pwm2_shape.sv
module pwm2_shape
  import pwm2_pkg::*;
(
  input  logic        run_i,
  input  logic        act_i,
  input  logic        phase_i,
  input  drive_mode_e mode_i,
  input  logic        inv_i,
  output logic        hi_o,
  output logic        lo_o
);

  logic raw_hi, raw_lo;

  always_comb begin
    raw_hi = 1'b0;
    raw_lo = 1'b0;
    if (run_i) begin
      unique case (mode_i)
        MD_COMPL: begin
          raw_hi = act_i;
          raw_lo = !act_i;
        end
        MD_ALT: begin
          raw_hi = act_i && !phase_i;
          raw_lo = act_i && phase_i;
        end
        default: begin
          raw_hi = act_i;
          raw_lo = 1'b0;
        end
      endcase
    end
    hi_o = raw_hi ^ inv_i;
    lo_o = raw_lo ^ inv_i;
  end

endmodule

// File: rtl/pwm2_gen.sv
module pwm2_gen
  import pwm2_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] duty_i,
  input  logic [2:0]    mode_i,
  input  logic          inv_i,
  output logic          out_hi,
  output logic          out_lo
);

  drive_mode_e req_mode, cur_mode;
  logic        run, act, phase, inv;

  pwm2_mode_sel u_sel (
    .mode_i (mode_i),
    .mode_o (req_mode)
  );

  pwm2_timebase #(.CW(CW)) u_tb (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .per_i   (period_i),
    .duty_i  (duty_i),
    .mode_i  (req_mode),
    .inv_i   (inv_i),
    .run_o   (run),
    .act_o   (act),
    .phase_o (phase),
    .mode_o  (cur_mode),
    .inv_o   (inv)
  );

  pwm2_shape u_shape (
    .run_i   (run),
    .act_i   (act),
    .phase_i (phase),
    .mode_i  (cur_mode),
    .inv_i   (inv),
    .hi_o    (out_hi),
    .lo_o    (out_lo)
  );

  a_r5_compl_opposite : assert property (@(posedge clk) disable iff (!rst_n)
    (run && cur_mode == MD_COMPL) |-> (out_hi != out_lo));

  a_r6_alt_one_side : assert property (@(posedge clk) disable iff (!rst_n)
    (run && cur_mode == MD_ALT) |-> !((out_hi ^ inv) && (out_lo ^ inv)));

  a_r4_single_lo_idle : assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MD_SINGLE) |-> (out_lo == inv));

  a_r9_idle_level : assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (out_hi == inv && out_lo == inv));

endmodule

// File: tb/test_pwm2_gen.sv
`timescale 1ns/1ps
module test_pwm2_gen;

  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en_i;
  logic [CW-1:0] period_i, duty_i;
  logic [2:0]    mode_i;
  logic          inv_i;
  logic          out_hi, out_lo;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pwm2_gen #(.CW(CW)) i_pwm2_gen (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .period_i(period_i),
    .duty_i(duty_i), .mode_i(mode_i), .inv_i(inv_i),
    .out_hi(out_hi), .out_lo(out_lo)
  );

  // Vector fields: mode(3) inv(1) period(8) duty(8)
  localparam logic [19:0] VEC [0:9] = '{
    {3'b001, 1'b0, 8'd5, 8'd2},   // R4 single
    {3'b010, 1'b0, 8'd6, 8'd3},   // R5 complementary
    {3'b100, 1'b0, 8'd4, 8'd1},   // R6 push-pull
    {3'b100, 1'b1, 8'd5, 8'd2},   // R7 push-pull inverted
    {3'b011, 1'b0, 8'd5, 8'd2},   // R2 -> single
    {3'b110, 1'b1, 8'd6, 8'd4},   // R2 -> complementary, inverted
    {3'b000, 1'b0, 8'd4, 8'd2},   // R2 zero -> single
    {3'b010, 1'b1, 8'd4, 8'd0},   // R3 duty zero
    {3'b001, 1'b0, 8'd4, 8'd9},   // R3 duty above period
    {3'b111, 1'b1, 8'd3, 8'd3}    // R1/R3 duty equals period
  };

  function automatic logic [1:0] model(input logic [2:0] m, input logic iv,
                                       input int p, input int d, input int k);
    int pe, c, idx;
    logic a, h, l;
    pe  = (p == 0) ? 1 : p;
    c   = k % pe;
    idx = k / pe;
    a   = (c < d);
    if (m[0] || m == 3'b000) begin h = a; l = 1'b0; end
    else if (m[1])           begin h = a; l = !a;   end
    else begin
      h = a && (idx % 2 == 0);
      l = a && (idx % 2 == 1);
    end
    return {h ^ iv, l ^ iv};
  endfunction

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {hi,lo} actual %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst_n = 1'b0; en_i = 1'b0; period_i = 8'd4; duty_i = 8'd2;
    mode_i = 3'b001; inv_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset", {out_hi, out_lo}, 2'b00);
    rst_n = 1'b1;
    step();
    chk("R9 idle inverted", {out_hi, out_lo}, 2'b11);

    // Table walk (R1-table covers R2, R3, R4, R5, R6, R7)
    for (int v = 0; v < 10; v++) begin
      logic [2:0] m;
      logic iv;
      int p, d;
      m = VEC[v][19:17]; iv = VEC[v][16];
      p = int'(VEC[v][15:8]); d = int'(VEC[v][7:0]);
      en_i = 1'b0; mode_i = m; inv_i = iv;
      period_i = VEC[v][15:8]; duty_i = VEC[v][7:0];
      step(); step();
      chk("R9 idle level", {out_hi, out_lo}, {iv, iv});
      en_i = 1'b1;
      for (int k = 0; k < 3 * p; k++) begin
        step();
        chk("R1 R2 R3 R4 R5 R6 R7 vector", {out_hi, out_lo}, model(m, iv, p, d, k));
      end
    end

    // R8: mid-period change only takes effect at the next period
    en_i = 1'b0; mode_i = 3'b001; inv_i = 1'b0; period_i = 8'd6; duty_i = 8'd2;
    step(); step();
    en_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R8 before change", {out_hi, out_lo}, model(3'b001, 1'b0, 6, 2, k));
    end
    period_i = 8'd4; duty_i = 8'd5;
    for (int k = 4; k < 6; k++) begin
      step();
      chk("R8 old period kept", {out_hi, out_lo}, 2'b00);
    end
    for (int k = 0; k < 8; k++) begin
      step();
      chk("R8 new settings", {out_hi, out_lo}, 2'b10);
    end

    // R6: push-pull restarts on the high side after leaving and re-entering
    en_i = 1'b0; mode_i = 3'b100; inv_i = 1'b0; period_i = 8'd4; duty_i = 8'd1;
    step(); step();
    en_i = 1'b1;
    for (int k = 0; k < 20; k++) begin
      logic [1:0] e;
      step();
      if (k % 4 != 0)    e = 2'b00;
      else if (k == 4)   e = 2'b01;
      else if (k == 16)  e = 2'b01;
      else               e = 2'b10;
      chk("R6 restart on high side", {out_hi, out_lo}, e);
      if (k == 4) mode_i = 3'b001;
      if (k == 8) mode_i = 3'b100;
    end

    // R9/R7: disable mid-run with inverted push-pull, then re-enable
    en_i = 1'b0; mode_i = 3'b100; inv_i = 1'b1; period_i = 8'd5; duty_i = 8'd2;
    step(); step();
    en_i = 1'b1;
    for (int k = 0; k < 7; k++) begin
      step();
      chk("R7 inverted push-pull", {out_hi, out_lo}, model(3'b100, 1'b1, 5, 2, k));
    end
    en_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R9 disabled mid-run", {out_hi, out_lo}, 2'b11);
    end
    en_i = 1'b1;
    step();
    chk("R9 restart at cycle 0", {out_hi, out_lo}, 2'b01);

    report();
  end

endmodule